// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

A 32-pin general-purpose I/O port behind a small 32-bit register port. Software drives pin levels through output data registers and selects each pin's direction through direction registers. It reads the live pin levels, after resynchronization, from one external port register. A constant identifier register lets software recognise the controller.

The 32 bits of output data and the 32 bits of direction are each split into a low half for pins 0-15 and a high half for pins 16-31. A write to any half carries a 16-bit enable mask in its upper bits. Only data bits whose enable bit is set change. Software can therefore set or clear a single pin with one store and no read-modify-write, and concurrent users of different pins cannot interfere.

The register port completes a write in the cycle it is presented. It returns read data one cycle after the address.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every data and direction bit is 0, so `pin_o` and `pin_oe_o` are all zero, and every storage register reads 0.
- R2: A write to the low data half (byte address 0x00) updates data bit k (pin k, k in 0..15) to `wdata_i[k]` only when `wdata_i[16+k]` is 1. Bits with a clear enable keep their value.
- R3: The high data half (address 0x04) holds pins 16-31. Pin p uses data bit p-16 and enable bit p. A write there never changes pins 0-15.
- R4: The direction halves at 0x08 (pins 0-15) and 0x0C (pins 16-31) follow the same masked-write rule. `pin_oe_o[p]` is 1 exactly when pin p's direction bit is 1, which makes the pin an output.
- R5: `pin_o[p]` equals pin p's stored data bit, whatever the direction. A direction write never changes `pin_o`.
- R6: A read of any split register returns its 16 stored bits in [15:0] and zeros in [31:16].
- R7: A read of 0x70 returns `pin_i` with bit n holding pin n, after a two-flop synchronizer. A level on `pin_i` before clock edge E is returned by a read whose address is presented for edge E+2.
- R8: A read of 0x78 always returns 0x0101157C, and writes to it have no effect.
- R9: Any other address, including a misaligned one, reads 0, and a write to it changes no register.
- R10: `rdata_o` takes the value for the address presented at a clock edge and holds it until the next edge. A write in that same cycle shows its new value only from the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 32 | Write data: [31:16] enables, [15:0] values |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Pad input levels, asynchronous |
| pin_o | output | 32 | Pad output values |
| pin_oe_o | output | 32 | Pad output enables, 1 = drive |

## Verification
The bench aims at the enable mask. A write with a zero mask must leave everything unchanged. Random masks must update only the selected bits, and a design that ignored the mask would clobber neighbouring pins. Writes to the high half must leave the low half alone, so a design that decoded the half wrongly would move pins 0-15. The bench also checks that direction writes leave the data outputs untouched.

It times the external port read exactly two synchronizer edges after a pin change. A design with one flop too few or too many returns stale or early data there. It also probes the identifier register, writes to it, and misaligned and unused addresses. A decoder that aliased those addresses would return nonzero data or corrupt a real register.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned HALF_W      = 16;
  localparam int unsigned BUS_W       = 32;
  localparam int unsigned DATA_BASE   = 'h00;
  localparam int unsigned DIR_BASE    = 'h08;
  localparam int unsigned EXT_ADDR    = 'h70;
  localparam int unsigned VER_ADDR    = 'h78;
  localparam logic [31:0] VERSION_ID  = 32'h0101_157C;
endpackage

// File: rtl/gpio_half_reg.sv
module gpio_half_reg
  import gpio_mask_pkg::*;
#(
  parameter int unsigned W = HALF_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [2*W-1:0] wdata_i,
  output logic [W-1:0]   q_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   q_o[k] <= 1'b0;
      else if (wr_i && wdata_i[W+k]) q_o[k] <= wdata_i[k];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1 <= '0;
      q_o    <= '0;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [BUS_W-1:0]    wdata_i,
  output logic [BUS_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam int unsigned NUM_HALVES = NUM_PINS / HALF_W;

  logic [NUM_PINS-1:0] pin_sync;
  logic [BUS_W-1:0]    rdata_d;
  logic [NUM_HALVES-1:0] data_hit, dir_hit;

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    assign data_hit[h] = (addr_i == ADDR_W'(DATA_BASE + 4*h));
    assign dir_hit[h]  = (addr_i == ADDR_W'(DIR_BASE + 4*h));

    gpio_half_reg #(.W(HALF_W)) u_data (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && data_hit[h]),
      .wdata_i (wdata_i[2*HALF_W-1:0]),
      .q_o     (pin_o[h*HALF_W +: HALF_W])
    );

    gpio_half_reg #(.W(HALF_W)) u_dir (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i && dir_hit[h]),
      .wdata_i (wdata_i[2*HALF_W-1:0]),
      .q_o     (pin_oe_o[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    rdata_d = '0;
    for (int h = 0; h < int'(NUM_HALVES); h++) begin
      if (data_hit[h]) rdata_d[HALF_W-1:0] = pin_o[h*HALF_W +: HALF_W];
      if (dir_hit[h])  rdata_d[HALF_W-1:0] = pin_oe_o[h*HALF_W +: HALF_W];
    end
    if (addr_i == ADDR_W'(EXT_ADDR)) rdata_d = BUS_W'(pin_sync);
    if (addr_i == ADDR_W'(VER_ADDR)) rdata_d = VERSION_ID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
  import gpio_mask_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  addr_i,
  input logic        we_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic [31:0] pin_i,
  input logic [31:0] pin_o,
  input logic [31:0] pin_oe_o
);
  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic split_a, known_a;
  assign split_a = (addr_i == 8'h00) || (addr_i == 8'h04) || (addr_i == 8'h08) || (addr_i == 8'h0C);
  assign known_a = split_a || (addr_i == 8'h70) || (addr_i == 8'h78);

  p_mask_update_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h00) |=>
      ((pin_o[15:0] & $past(wdata_i[31:16])) == ($past(wdata_i[15:0]) & $past(wdata_i[31:16]))));

  p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h00 && wdata_i[31:16] == 16'h0) |=> $stable(pin_o));

  p_hi_keeps_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h04) |=> $stable(pin_o[15:0]));

  p_dir_update_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 8'h08) |=>
      ((pin_oe_o[15:0] & $past(wdata_i[31:16])) == ($past(wdata_i[15:0]) & $past(wdata_i[31:16]))));

  p_dir_keeps_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == 8'h08 || addr_i == 8'h0C)) |=> $stable(pin_o));

  p_split_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split_a |=> (rdata_o[31:16] == 16'h0));

  p_sync_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h70 && age == 2'd3) |=> (rdata_o == $past(pin_i, 3)));

  p_version_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h78) |=> (rdata_o == VERSION_ID));

  p_unused_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_a |=> (rdata_o == 32'h0));

  p_unused_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !split_a) |=> ($stable(pin_o) && $stable(pin_oe_o)));
endmodule

bind gpio_mask_port gpio_mask_port_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pin_i    (pin_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o)
);

// File: tb/tb_gpio_mask_port.sv
module tb_gpio_mask_port;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] m_data = '0;
  logic [31:0] m_dir  = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_mask_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  function automatic logic [15:0] merge16(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a, logic [31:0] ext);
    case (a)
      8'h00: return {16'h0, m_data[15:0]};
      8'h04: return {16'h0, m_data[31:16]};
      8'h08: return {16'h0, m_dir[15:0]};
      8'h0C: return {16'h0, m_dir[31:16]};
      8'h70: return ext;
      8'h78: return 32'h0101_157C;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] w);
    @(negedge clk_i);
    addr_i = a; wdata_i = w; we_i = 1'b1;
    case (a)
      8'h00: m_data[15:0]  = merge16(m_data[15:0], w);
      8'h04: m_data[31:16] = merge16(m_data[31:16], w);
      8'h08: m_dir[15:0]   = merge16(m_dir[15:0], w);
      8'h0C: m_dir[31:16]  = merge16(m_dir[31:16], w);
      default: ;
    endcase
    @(negedge clk_i);
    we_i = 1'b0;
    check("R5 pin_o", pin_o, m_data);
    check("R4 pin_oe_o", pin_oe_o, m_dir);
  endtask

  task automatic do_read(logic [7:0] a, string req);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0;
    @(negedge clk_i);
    check(req, rdata_o, exp_read(a, pin_i));
  endtask

  logic [7:0] addr_pool [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h70, 8'h78, 8'h10, 8'h01, 8'h74, 8'h3C};

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1 pin_o", pin_o, 32'h0);
    check("R1 pin_oe_o", pin_oe_o, 32'h0);
    do_read(8'h00, "R1 data lo");
    do_read(8'h0C, "R1 dir hi");
    // R2 single-bit set, zero mask
    do_write(8'h00, 32'h0020_FFFF);
    check("R2 single bit", pin_o, 32'h0000_0020);
    do_write(8'h00, 32'h0000_FFFF);
    check("R2 zero mask", pin_o, 32'h0000_0020);
    // R3 high half
    do_write(8'h04, 32'h8001_FFFF);
    check("R3 hi half", pin_o, 32'h8001_0020);
    do_read(8'h04, "R6 hi readback");
    // R4 direction, R5 data unaffected
    do_write(8'h08, 32'hFFFF_00F0);
    do_write(8'h0C, 32'h0003_0002);
    check("R4 oe", pin_oe_o, 32'h0002_00F0);
    check("R5 data kept", pin_o, 32'h8001_0020);
    // R8 version, write ignored
    do_write(8'h78, 32'hFFFF_FFFF);
    do_read(8'h78, "R8 version");
    // R9 unused/misaligned writes
    do_write(8'h01, 32'hFFFF_FFFF);
    do_write(8'h10, 32'hFFFF_FFFF);
    do_read(8'h01, "R9 misaligned");
    do_read(8'h00, "R9 data intact");
    // R7 sync timing: changed before edge E, read presented for E+2
    @(negedge clk_i);
    pin_i = 32'hA5C3_0F96;
    addr_i = 8'h70;
    @(negedge clk_i);
    check("R7 too early", rdata_o, 32'h0);
    @(negedge clk_i);
    check("R7 still early", rdata_o, 32'h0);
    @(negedge clk_i);
    check("R7 ext port", rdata_o, 32'hA5C3_0F96);
    // R10 same-cycle write/read returns old value
    @(negedge clk_i);
    addr_i = 8'h08; wdata_i = 32'hFFFF_1234; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    check("R10 old value", rdata_o, {16'h0, m_dir[15:0]});
    m_dir[15:0] = 16'h1234;
    @(negedge clk_i);
    check("R10 new value", rdata_o, 32'h0000_1234);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = addr_pool[$urandom_range(9, 0)];
      case ($urandom_range(3, 0))
        0, 1: do_write(a, $urandom());
        2: do_read(a, "R2 R6 R9 random read");
        default: begin
          @(negedge clk_i);
          pin_i = $urandom();
          repeat (2) @(negedge clk_i);
          do_read(8'h70, "R7 random ext");
        end
      endcase
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule